// File: doc/BRIEF.md
# Bit-Select Command Register Bank

This block is a small bank of 32-bit control registers reached through a plain memory-mapped write/read port. Software never has to read a register before changing it. Each byte of a written word is a command to one lane of the register. The top bit of the byte gives a level. The lower seven bits mark which register bits take that level. Register bits that are not marked keep their current state.

Each register has its own parameterised address, its own mask of implemented bits and its own reset value. Bits outside the mask are never stored and always read as zero. The byte enables gate each lane, so a lane with a low enable leaves that part of the register alone. Readback is combinational and returns the stored contents of the addressed register, so a write becomes visible on the cycle after the clock edge that takes it.

Top module: `cmdreg_bank`

## Requirements
- R1: After reset each register reads its reset value ANDed with its implemented-bit mask. With the default parameters the registers at byte addresses 0x40, 0x48, 0x50, 0x54 and 0x64 read 0x00000000, 0x00000000, 0x00000041, 0x203C7E07 and 0x00000000.
- R2: When bit 7 of a byte lane is 1, a write sets every implemented register bit whose select bit (lane bits 6:0) is 1. For example, writing 0x9A to lane 0 sets bits 1, 3 and 4.
- R3: When bit 7 of a byte lane is 0, a write clears every implemented register bit whose select bit is 1. Register bits whose select bit is 0 keep their state.
- R4: The four lanes act independently within one write. One lane may set bits while another lane clears bits.
- R5: A lane whose byte enable (be[n] for bits 8n+7:8n) is low changes nothing, even if its data bits are nonzero.
- R6: Register bit positions outside the implemented-bit mask, and the lane value-bit positions 31, 23, 15 and 7, always read as zero. Select bits aimed at those positions have no effect.
- R7: A write to an address that matches no register changes no register. A read of such an address returns zero.
- R8: During the cycle of a write, a read of the same register returns the contents from before the write. The new contents appear after the clock edge.
- R9: A write changes only the register at the matching address.
- R10: Writing a register's implemented mask with all value bits at zero clears every bit of that register. For example, 0x000F0F7F clears the register at 0x48.
- R11: With wr_en low, no register changes, whatever the address, data and byte enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (9) | Byte address for writes and reads |
| wdata | input | DATA_W (32) | Write data: four lanes of value bit plus seven select bits |
| be | input | DATA_W/8 (4) | Byte enables, one per lane |
| rdata | output | DATA_W (32) | Contents of the addressed register, zero when no register matches |

## Verification
The bench targets the places where a set/clear decode usually goes wrong. A design that stored the value bit, or treated the write as a plain overwrite, would corrupt the unselected bits or show ones at bit 7, 15, 23 or 31. A design that ignored the byte enables, or shared a single value bit across lanes, would change lanes it should leave alone in the mixed set-and-clear writes. The bench also writes ones to unimplemented positions and to unmapped addresses, and then reads back neighbouring registers, which exposes a loose mask or a partial address compare. It samples a read in the same cycle as the write, which catches a design that forwards write data or registers its read path.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
   localparam int LANE_W = 8;
   localparam int SEL_W  = LANE_W - 1;

   // One byte lane of a write word: level in the top bit, selects below
   typedef struct packed {
      logic             val;
      logic [SEL_W-1:0] sel;
   } lane_cmd_t;
endpackage

// File: rtl/cmdreg_addr_match.sv
module cmdreg_addr_match #(
   parameter int NUM_REGS = 5,
   parameter int ADDR_W   = 9,
   parameter logic [NUM_REGS-1:0][31:0] OFFS = '0
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] hit
);
   // Full byte-address compare: a partial or misaligned address never hits
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
         assign hit[i] = (addr == OFFS[i][ADDR_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/cmdreg_lane.sv
module cmdreg_lane
   import cmdreg_pkg::*;
#(
   parameter logic [SEL_W-1:0] IMPL = '1,
   parameter logic [SEL_W-1:0] RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  lane_cmd_t         cmd,
   output logic [LANE_W-1:0] q
);
   localparam logic [SEL_W-1:0] RST_EFF = RST & IMPL;

   logic [SEL_W-1:0] sel_eff;
   logic [SEL_W-1:0] st_q;
   logic [SEL_W-1:0] st_d;

   // Unimplemented positions can never be selected
   assign sel_eff = cmd.sel & IMPL;

   always_comb begin
      st_d = st_q;
      if (we) begin
         if (cmd.val) st_d = st_q | sel_eff;
         else         st_d = st_q & ~sel_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RST_EFF;
      else        st_q <= st_d;
   end

   // The level bit is a command field only; it has no storage behind it
   assign q = {1'b0, st_q & IMPL};
endmodule

// File: rtl/cmdreg_word.sv
module cmdreg_word
   import cmdreg_pkg::*;
#(
   parameter int                DATA_W = 32,
   parameter logic [DATA_W-1:0] MASK   = '0,
   parameter logic [DATA_W-1:0] RSTV   = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [DATA_W/LANE_W-1:0]   be,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          q
);
   localparam int LANES = DATA_W / LANE_W;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam logic [SEL_W-1:0] L_IMPL = MASK[l*LANE_W +: SEL_W];
         localparam logic [SEL_W-1:0] L_RST  = RSTV[l*LANE_W +: SEL_W];
         if (L_IMPL == '0) begin : g_empty
            // Lane with no implemented bit: no storage at all
            logic lane_unused;
            assign lane_unused = ^{wdata[l*LANE_W +: LANE_W], be[l]};
            assign q[l*LANE_W +: LANE_W] = '0;
         end else begin : g_live
            lane_cmd_t cmd;
            assign cmd = lane_cmd_t'(wdata[l*LANE_W +: LANE_W]);
            cmdreg_lane #(
               .IMPL(L_IMPL),
               .RST (L_RST)
            ) u_lane (
               .clk  (clk),
               .rst_n(rst_n),
               .we   (we & be[l]),
               .cmd  (cmd),
               .q    (q[l*LANE_W +: LANE_W])
            );
         end
      end
   endgenerate
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
   import cmdreg_pkg::*;
#(
   parameter int NUM_REGS = 5,
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 32,
   parameter logic [NUM_REGS-1:0][31:0] OFFS =
      {32'h64, 32'h54, 32'h50, 32'h48, 32'h40},
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] MASK =
      {32'h0000001B, 32'h203C7E07, 32'h3F7F3F7F, 32'h000F0F7F, 32'h1F7F7F1F},
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] RSTV =
      {32'h00000004, 32'hFFFFFFFF, 32'h00000041, 32'h00000000, 32'h00000000}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [DATA_W/LANE_W-1:0]   be,
   output logic [DATA_W-1:0]          rdata
);
   localparam int LANES = DATA_W / LANE_W;

   function automatic logic [DATA_W-1:0] level_bits();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int l = 0; l < LANES; l++) m[l*LANE_W + SEL_W] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] LEVEL_POS = level_bits();

   // Elaboration-time parameter checks
   generate
      if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin : g_bad_width
         $error("cmdreg_bank: DATA_W must be a nonzero multiple of 8");
      end
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("cmdreg_bank: ADDR_W out of range");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_pchk
         if ((MASK[i] & LEVEL_POS) != '0) begin : g_mask_lvl
            $error("cmdreg_bank: a mask covers a lane level bit");
         end
         if (OFFS[i][1:0] != 2'b00) begin : g_align
            $error("cmdreg_bank: register offset not word aligned");
         end
         for (genvar j = i + 1; j < NUM_REGS; j++) begin : g_dup
            if (OFFS[i][ADDR_W-1:0] == OFFS[j][ADDR_W-1:0]) begin : g_same
               $error("cmdreg_bank: two registers share one offset");
            end
         end
      end
   endgenerate

   logic [NUM_REGS-1:0]              hit;
   logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q;

   cmdreg_addr_match #(
      .NUM_REGS(NUM_REGS),
      .ADDR_W  (ADDR_W),
      .OFFS    (OFFS)
   ) u_match (
      .addr(addr),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         cmdreg_word #(
            .DATA_W(DATA_W),
            .MASK  (MASK[i]),
            .RSTV  (RSTV[i])
         ) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_en & hit[i]),
            .be   (be),
            .wdata(wdata),
            .q    (reg_q[i])
         );
      end
   endgenerate

   // Combinational readback of stored state: pre-write value in the write cycle
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hit[i]) rdata = rdata | reg_q[i];
      end
   end
endmodule

// File: rtl/cmdreg_bank_chk.sv
module cmdreg_bank_chk #(
   parameter int NUM_REGS = 5,
   parameter int DATA_W   = 32,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] MASK = '0,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] RSTV = '0
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             wr_en,
   input logic [DATA_W-1:0]                wdata,
   input logic [DATA_W/8-1:0]              be,
   input logic [NUM_REGS-1:0]              hit,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
   input logic [DATA_W-1:0]                rdata
);
   localparam int LANES = DATA_W / 8;

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // Decoder never selects two registers at once (R9)
   p_onehot_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // Unmapped writes leave every register alone (R7)
   p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit == '0) |=> $stable(regs));

   // No strobe, no change (R11)
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs));

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_r
         // First sampled cycle after reset shows masked reset value (R1)
         p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !live |-> (regs[i] == (RSTV[i] & MASK[i])));

         // Nothing outside the mask is ever held (R6)
         p_impl_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[i] & ~MASK[i]) == '0);

         for (genvar l = 0; l < LANES; l++) begin : g_l
            localparam logic [6:0] LM = MASK[i][l*8 +: 7];

            // Level 1 sets the selected implemented bits (R2)
            p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && hit[i] && be[l] && wdata[l*8+7]) |=>
               ((regs[i][l*8 +: 7] & ($past(wdata[l*8 +: 7]) & LM)) ==
                ($past(wdata[l*8 +: 7]) & LM)));

            // Level 0 clears the selected bits (R3)
            p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && hit[i] && be[l] && !wdata[l*8+7]) |=>
               ((regs[i][l*8 +: 7] & $past(wdata[l*8 +: 7])) == 7'd0));

            // Unselected bits of a written lane keep their state (R3)
            p_keep_unsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && hit[i] && be[l]) |=>
               ((regs[i][l*8 +: 7] & ~$past(wdata[l*8 +: 7])) ==
                ($past(regs[i][l*8 +: 7]) & ~$past(wdata[l*8 +: 7]))));

            // A lane not enabled for this register holds (R5)
            p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
               !(wr_en && hit[i] && be[l]) |=> $stable(regs[i][l*8 +: 8]));
         end
      end

      for (genvar l = 0; l < LANES; l++) begin : g_rd
         // Level-bit positions never read back as one (R6)
         p_lvl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[l*8+7] == 1'b0);
      end
   endgenerate
endmodule

bind cmdreg_bank cmdreg_bank_chk #(
   .NUM_REGS(NUM_REGS),
   .DATA_W  (DATA_W),
   .MASK    (MASK),
   .RSTV    (RSTV)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .wr_en(wr_en),
   .wdata(wdata),
   .be   (be),
   .hit  (hit),
   .regs (reg_q),
   .rdata(rdata)
);

// File: tb/sim_cmdreg_bank.sv
`timescale 1ns/1ps
module sim_cmdreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic [31:0] rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [8:0] A0 = 9'h040, A1 = 9'h048, A2 = 9'h050,
                          A3 = 9'h054, A4 = 9'h064;

   always #2 clk = ~clk;   // 250 MHz

   cmdreg_bank u0 (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .addr (addr),
      .wdata(wdata),
      .be   (be),
      .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] b);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr_en = 1'b0; be = '0; wdata = '0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      wr_en = 1'b0; addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A0, v); chk("R1 reg@40", v, 32'h00000000);
      rd(A1, v); chk("R1 reg@48", v, 32'h00000000);
      rd(A2, v); chk("R1 reg@50", v, 32'h00000041);
      rd(A3, v); chk("R1 reg@54", v, 32'h203C7E07);
      rd(A4, v); chk("R1 reg@64", v, 32'h00000000);
   endtask

   task automatic t_set_clear();
      logic [31:0] v;
      wr(A1, 32'h0000009A, 4'hF);
      rd(A1, v); chk("R2 set 1,3,4", v, 32'h0000001A);
      wr(A1, 32'h000000FF, 4'hF);
      rd(A1, v); chk("R2 set lane0", v, 32'h0000007F);
      wr(A1, 32'h0000001A, 4'hF);
      rd(A1, v); chk("R3 clear 1,3,4", v, 32'h00000065);
   endtask

   task automatic t_lanes();
      logic [31:0] v;
      wr(A1, 32'h00008F00, 4'hF);
      rd(A1, v); chk("R4 set lane1", v, 32'h00000F65);
      wr(A1, 32'h008F0301, 4'hF);
      rd(A1, v); chk("R4 mixed set/clear", v, 32'h000F0C64);
   endtask

   task automatic t_byte_en();
      logic [31:0] v;
      wr(A1, 32'h7F7F7F7F, 4'b0000);
      rd(A1, v); chk("R5 no lanes enabled", v, 32'h000F0C64);
      wr(A1, 32'h7F7F7F7F, 4'b0010);
      rd(A1, v); chk("R5 lane1 only", v, 32'h000F0064);
   endtask

   task automatic t_idle();
      logic [31:0] v;
      @(negedge clk);
      wr_en = 1'b0; addr = A1; wdata = 32'h7F7F7F7F; be = 4'hF;
      @(negedge clk);
      be = '0; wdata = '0;
      rd(A1, v); chk("R11 strobe low", v, 32'h000F0064);
   endtask

   task automatic t_same_cycle();
      logic [31:0] pre, post;
      @(negedge clk);
      wr_en = 1'b1; addr = A1; wdata = 32'h00000081; be = 4'b0001;
      #1 pre = rdata;
      @(posedge clk);
      #1 post = rdata;
      @(negedge clk);
      wr_en = 1'b0; be = '0; wdata = '0;
      chk("R8 read during write", pre, 32'h000F0064);
      chk("R8 read after edge", post, 32'h000F0065);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr(A4, 32'hFFFFFFFF, 4'hF);
      rd(A4, v); chk("R6 reg@64 all ones", v, 32'h0000001B);
      wr(A4, 32'h0000007F, 4'hF);
      wr(A4, 32'h00000084, 4'hF);
      rd(A4, v); chk("R6 select unimplemented bit", v, 32'h00000000);
      wr(A0, 32'hFFFFFFFF, 4'hF);
      rd(A0, v); chk("R6 level bits read zero", v, 32'h1F7F7F1F);
   endtask

   task automatic t_clear_all();
      logic [31:0] v;
      wr(A0, 32'h1F7F7F1F, 4'hF);
      rd(A0, v); chk("R10 clear reg@40", v, 32'h00000000);
      wr(A2, 32'h3F7F3F7F, 4'hF);
      rd(A2, v); chk("R10 clear reg@50", v, 32'h00000000);
      wr(A1, 32'h000F0F7F, 4'hF);
      rd(A1, v); chk("R10 clear reg@48", v, 32'h00000000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(9'h044, 32'h7F7F7F7F, 4'hF);
      wr(9'h056, 32'hFFFFFFFF, 4'hF);
      rd(9'h044, v); chk("R7 read unmapped", v, 32'h00000000);
      rd(9'h04A, v); chk("R7 read misaligned", v, 32'h00000000);
      rd(A3, v); chk("R7 reg@54 untouched", v, 32'h203C7E07);
      rd(A1, v); chk("R7 reg@48 untouched", v, 32'h00000000);
   endtask

   task automatic t_isolation();
      logic [31:0] v;
      wr(A3, 32'h00007F00, 4'hF);
      rd(A3, v); chk("R9 target reg@54", v, 32'h203C0007);
      rd(A1, v); chk("R9 reg@48 unchanged", v, 32'h00000000);
      rd(A2, v); chk("R9 reg@50 unchanged", v, 32'h00000000);
      rd(A4, v); chk("R9 reg@64 unchanged", v, 32'h00000000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_lanes();
      t_byte_en();
      t_idle();
      t_same_cycle();
      t_mask();
      t_clear_all();
      t_unmapped();
      t_isolation();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule